// File: doc/BRIEF.md
# USB Low-Level Packet Transmitter

This block converts a single packet request into the serial line sequence of a full USB low-level packet on the D+/D- pair. A caller presents the packet kind, a 7-bit device address, a 4-bit endpoint and an 8-byte payload, and pulses `start`. The block then sends one line symbol per clock: the synchronisation pattern, the packet identifier, the token fields or the data bytes, the CRC, and the end-of-packet marker. It then releases the wires and raises `done` for one clock.

Every stage works on the bit that is on its way to the wire. A serialiser picks the current bit, a CRC register absorbs it, a stuffer replaces it with a forced zero when six ones have gone out in a row, and an NRZI stage turns it into a line level. A stuffed zero holds the serialiser and the CRC for that clock. The packet is never assembled first and processed afterwards. The wire drivers are tri-state: `tx_oe` enables them, and while it is low the bus pull-downs hold both lines at 0.

Top module: `usb_pkt_tx`

## Requirements
- R1: While reset is held or no packet is in flight, `tx_oe`, `tx_dp`, `tx_dm` and `done` are 0. A reset in mid-packet releases the wires at once.
- R2: Once `start` is sampled with a valid kind, the next clock begins the packet. Its first eight symbols are K J K J K J K K, where J is dp=1, dm=0 and K is dp=0, dm=1.
- R3: The kind codes are 0=OUT, 1=IN, 2=DATA0, 3=ACK and 4=NAK. The 4-bit type codes are OUT 0001, IN 1001, DATA0 0011, ACK 0010 and NAK 1010. The identifier byte is the code in bits 3:0 with its complement in bits 7:4, sent bit 0 first, straight after the sync pattern.
- R4: From the sync pattern through the CRC, a 0 bit changes the line between J and K and a 1 bit keeps it. The level before the first sync bit is taken as J.
- R5: An OUT or IN packet carries the address (bit 0 first) and then the endpoint (bit 0 first), followed by CRC5. CRC5 uses x^5+x^2+1, starts from all ones, and is sent complemented, MSB first. Run through the same CRC over its 16 bits, the token leaves residue 01100.
- R6: A DATA0 packet carries `payload` bit 0 first (byte 0 first), followed by CRC16. CRC16 uses x^16+x^15+x^2+1, starts from all ones, and is sent complemented, MSB first. Run through the same CRC over its 80 bits, the packet leaves residue 16'h800D.
- R7: After six consecutive 1 bits in the field, data or CRC region (counting from the first bit after the identifier, up to and including the last CRC bit), one 0 is inserted. The sync pattern and the identifier are never stuffed, and the packet grows by one clock for each inserted 0.
- R8: An ACK or NAK packet goes straight from the identifier to the end-of-packet marker.
- R9: Every packet ends with two symbols of dp=0, dm=0 and then one J. In the clock after that, `tx_oe` is 0.
- R10: `done` is high for exactly the one clock that follows the final J, and `tx_oe` is already 0 in that clock.
- R11: A `start` that arrives while a packet is in flight has no effect on that packet and does not queue a second packet.
- R12: A `start` with a kind code of 5, 6 or 7 is ignored, and the wires stay released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, one line symbol per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request strobe, sampled when idle |
| pkt_kind | input | 3 | Packet kind code (see R3) |
| dev_addr | input | 7 | Device address for tokens |
| endp | input | 4 | Endpoint number for tokens |
| payload | input | 8*DATA_BYTES | Data bytes for DATA0, byte 0 in bits 7:0 |
| tx_oe | output | 1 | Output enable of both tri-state drivers |
| tx_dp | output | 1 | Value driven on D+ while enabled |
| tx_dm | output | 1 | Value driven on D- while enabled |
| done | output | 1 | One-clock pulse after the end of a packet |

## Verification
The packet's first symbol appears in the clock after the edge that samples `start`. Each later symbol follows one clock after the previous one, and each stuffed zero adds one clock. `done` rises in the clock after the final J, which is the first clock with `tx_oe` low. The bench drives its inputs on falling edges and captures one symbol on every falling edge while `tx_oe` is high. It reads `done` on the first falling edge with `tx_oe` low and again one clock later. Every decoded field, stuffing position and CRC residue is worked out from that captured stream, so no check depends on an absolute cycle count.

// File: rtl/usb_pkt_tx.sv
module usb_pkt_tx #(
  parameter int DATA_BYTES = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [2:0]              pkt_kind,
  input  logic [6:0]              dev_addr,
  input  logic [3:0]              endp,
  input  logic [DATA_BYTES*8-1:0] payload,
  output logic                    tx_oe,
  output logic                    tx_dp,
  output logic                    tx_dm,
  output logic                    done
);
  localparam int DBITS = DATA_BYTES * 8;
  localparam int CW = $clog2(DBITS > 16 ? DBITS : 16) + 1;
  localparam logic [CW-1:0] LAST_DATA = CW'(DBITS - 1);
  localparam logic [CW-1:0] LAST_TOK  = CW'(10);
  localparam logic [CW-1:0] LAST_C16  = CW'(15);
  localparam logic [CW-1:0] LAST_C5   = CW'(4);
  localparam logic [CW-1:0] LAST_BYTE = CW'(7);
  localparam logic [CW-1:0] LAST_EOP  = CW'(2);
  localparam logic [2:0] K_OUT = 3'd0, K_IN = 3'd1, K_DATA = 3'd2, K_ACK = 3'd3, K_NAK = 3'd4;

  typedef enum logic [2:0] {S_IDLE, S_SYNC, S_PID, S_BODY, S_CRC, S_TAIL, S_EOP} st_t;

  st_t              state;
  logic [CW-1:0]    cnt;
  logic [2:0]       kind_q;
  logic [DBITS-1:0] sh;
  logic [15:0]      crc, crc_fed, crc_sh;
  logic [2:0]       ones;
  logic             lvl;
  logic [3:0]       pid_code;
  logic             cur, nrzi, stuff, is_data, is_hs, crc_top, fb;

  always_comb begin
    case (kind_q)
      K_OUT:   pid_code = 4'b0001;
      K_IN:    pid_code = 4'b1001;
      K_DATA:  pid_code = 4'b0011;
      K_ACK:   pid_code = 4'b0010;
      K_NAK:   pid_code = 4'b1010;
      default: pid_code = 4'b0000;
    endcase
  end

  assign is_data = (kind_q == K_DATA);
  assign is_hs   = (kind_q == K_ACK) || (kind_q == K_NAK);
  assign crc_top = is_data ? crc[15] : crc[4];
  assign stuff   = (state == S_BODY || state == S_CRC || state == S_TAIL) && (ones == 3'd6);
  assign fb      = sh[0] ^ crc_top;
  assign crc_sh  = is_data ? {crc[14:0], 1'b0} : {11'b0, crc[3:0], 1'b0};
  assign crc_fed = crc_sh ^ (fb ? (is_data ? 16'h8005 : 16'h0005) : 16'h0000);

  always_comb begin
    case (state)
      S_SYNC:  cur = (cnt == LAST_BYTE);
      S_PID:   cur = (cnt[2:0] < 3'd4) ? pid_code[cnt[1:0]] : ~pid_code[cnt[1:0]];
      S_BODY:  cur = stuff ? 1'b0 : sh[0];
      S_CRC:   cur = stuff ? 1'b0 : ~crc_top;
      default: cur = 1'b0;
    endcase
  end

  assign nrzi  = cur ? lvl : ~lvl;
  assign tx_oe = (state != S_IDLE);
  assign tx_dp = (state == S_EOP) ? (cnt == LAST_EOP) : (tx_oe & nrzi);
  assign tx_dm = (state == S_EOP) ? 1'b0 : (tx_oe & ~nrzi);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      cnt    <= '0;
      kind_q <= '0;
      sh     <= '0;
      crc    <= '1;
      ones   <= '0;
      lvl    <= 1'b1;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start && pkt_kind <= K_NAK) begin
          state  <= S_SYNC;
          cnt    <= '0;
          kind_q <= pkt_kind;
          sh     <= (pkt_kind == K_DATA) ? payload : {{(DBITS-11){1'b0}}, endp, dev_addr};
          crc    <= '1;
          ones   <= '0;
          lvl    <= 1'b1;
        end
        S_SYNC: begin
          lvl <= nrzi;
          if (cnt == LAST_BYTE) begin
            state <= S_PID;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        S_PID: begin
          lvl <= nrzi;
          if (cnt == LAST_BYTE) begin
            state <= is_hs ? S_EOP : S_BODY;
            cnt   <= '0;
            ones  <= '0;
          end else cnt <= cnt + 1'b1;
        end
        S_BODY: begin
          lvl <= nrzi;
          if (stuff) ones <= '0;
          else begin
            ones <= cur ? ones + 1'b1 : 3'd0;
            sh   <= sh >> 1;
            crc  <= crc_fed;
            if (cnt == (is_data ? LAST_DATA : LAST_TOK)) begin
              state <= S_CRC;
              cnt   <= '0;
            end else cnt <= cnt + 1'b1;
          end
        end
        S_CRC: begin
          lvl <= nrzi;
          if (stuff) ones <= '0;
          else begin
            ones <= cur ? ones + 1'b1 : 3'd0;
            crc  <= crc_sh;
            if (cnt == (is_data ? LAST_C16 : LAST_C5)) begin
              state <= (cur && ones == 3'd5) ? S_TAIL : S_EOP;
              cnt   <= '0;
            end else cnt <= cnt + 1'b1;
          end
        end
        S_TAIL: begin
          lvl   <= nrzi;
          ones  <= '0;
          state <= S_EOP;
        end
        S_EOP: begin
          if (cnt == LAST_EOP) begin
            state <= S_IDLE;
            cnt   <= '0;
            done  <= 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_sync_opens_with_k_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_oe) |-> (!tx_dp && tx_dm));

  assert_run_never_past_six_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_oe |-> (ones <= 3'd6));

  assert_eop_releases_wires_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_EOP && cnt == LAST_EOP) |=> !tx_oe);

  assert_done_after_final_j_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!tx_oe && $past(tx_oe && tx_dp && !tx_dm)));

  assert_done_single_clock_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_busy_start_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_oe && start) |=> $stable(kind_q));

  assert_bad_kind_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_oe && start && pkt_kind > K_NAK) |=> !tx_oe);
endmodule

// File: tb/tb_usb_pkt_tx.sv
`timescale 1ns/1ps
module tb_usb_pkt_tx;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [2:0] kind = '0;
  logic [6:0] addr = '0;
  logic [3:0] ep = '0;
  logic [63:0] pl = '0;
  logic oe, dp, dm, done;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  usb_pkt_tx dut (.clk(clk), .rst_n(rst_n), .start(start), .pkt_kind(kind), .dev_addr(addr),
                  .endp(ep), .payload(pl), .tx_oe(oe), .tx_dp(dp), .tx_dm(dm), .done(done));

  localparam int NV = 9;
  localparam logic [77:0] VEC [NV] = '{
    {3'd0, 7'd5,   4'd4,   64'h0},
    {3'd1, 7'd5,   4'd8,   64'h0},
    {3'd0, 7'h7f,  4'hf,   64'h0},
    {3'd2, 7'd0,   4'd0,   64'h0},
    {3'd2, 7'd0,   4'd0,   64'hffff_ffff_ffff_ffff},
    {3'd2, 7'd0,   4'd0,   64'h0123_4567_89ab_cdef},
    {3'd3, 7'd0,   4'd0,   64'h0},
    {3'd4, 7'd0,   4'd0,   64'h0},
    {3'd1, 7'd0,   4'd0,   64'h0}
  };

  logic [1:0] sym [0:399];
  int nsym;
  logic done_seen, done_after;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] code_of(input logic [2:0] k);
    case (k)
      3'd0: return 4'b0001;
      3'd1: return 4'b1001;
      3'd2: return 4'b0011;
      3'd3: return 4'b0010;
      default: return 4'b1010;
    endcase
  endfunction

  task automatic send(input logic [2:0] k, input logic [6:0] a, input logic [3:0] e,
                      input logic [63:0] p, input int poke);
    @(negedge clk);
    kind = k; addr = a; ep = e; pl = p; start = 1'b1;
    nsym = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      start = 1'b0;
      if (!oe) break;
      sym[nsym] = {dp, dm};
      nsym++;
      if (i == poke) begin
        start = 1'b1; kind = 3'd2; addr = 7'h7f; ep = 4'hf; pl = '1;
      end
    end
    done_seen = done;
    @(negedge clk);
    done_after = done;
  endtask

  task automatic verify(input logic [2:0] k, input logic [6:0] a, input logic [3:0] e, input logic [63:0] p);
    logic [15:0] sy;
    logic [7:0] pid;
    logic [127:0] body;
    logic [1:0] prev;
    logic raw, bad_sym, stuff_err;
    logic [15:0] r;
    int ones, m, nb, cw, top;
    sy = '0;
    for (int i = 0; i < 8; i++) sy = {sy[13:0], sym[i]};
    chk(nsym > 12, "R2 packet length", 64'(nsym), 64'd13);
    chk(sy == 16'h6665, "R2 sync symbols", 64'(sy), 64'h6665);
    chk({sym[nsym-3], sym[nsym-2], sym[nsym-1]} == 6'b00_00_10, "R9 end marker",
        64'({sym[nsym-3], sym[nsym-2], sym[nsym-1]}), 64'b00_00_10);
    prev = sym[7]; bad_sym = 1'b0; stuff_err = 1'b0; ones = 0; m = 0; pid = '0; body = '0;
    for (int i = 8; i < nsym - 3; i++) begin
      if (sym[i] != 2'b10 && sym[i] != 2'b01) bad_sym = 1'b1;
      raw = (sym[i] == prev);
      prev = sym[i];
      if (i < 16) pid[i-8] = raw;
      else if (ones == 6) begin
        if (raw) stuff_err = 1'b1;
        ones = 0;
      end else begin
        if (m < 128) body[m] = raw;
        m++;
        ones = raw ? ones + 1 : 0;
      end
    end
    chk(!bad_sym, "R4 only J or K before end marker", 64'(bad_sym), 64'd0);
    chk(pid == {~code_of(k), code_of(k)}, "R3 identifier byte", 64'(pid), 64'({~code_of(k), code_of(k)}));
    chk(!stuff_err, "R7 zero after six ones", 64'(stuff_err), 64'd0);
    nb = (k == 3'd2) ? 64 : (k <= 3'd1 ? 11 : 0);
    cw = (k == 3'd2) ? 16 : (k <= 3'd1 ? 5 : 0);
    chk(m == nb + cw, (nb == 0) ? "R8 nothing after identifier" : "R7 unstuffed length", 64'(m), 64'(nb + cw));
    if (k == 3'd2) chk(body[63:0] == p, "R6 payload bits", body[63:0], p);
    if (k <= 3'd1) chk(body[10:0] == {e, a}, "R5 token fields", 64'(body[10:0]), 64'({e, a}));
    if (nb > 0) begin
      r = '1; top = cw - 1;
      for (int i = 0; i < m; i++) begin
        if (body[i] ^ r[top]) r = (r << 1) ^ ((cw == 16) ? 16'h8005 : 16'h0005);
        else r = r << 1;
        if (cw == 5) r = r & 16'h001f;
      end
      if (cw == 16) chk(r == 16'h800d, "R6 crc16 residue", 64'(r), 64'h800d);
      else chk(r == 16'h000c, "R5 crc5 residue", 64'(r), 64'h000c);
    end
    chk(done_seen && !done_after, "R10 done pulse", 64'({done_seen, done_after}), 64'b10);
  endtask

  initial begin
    #(200000 * 5);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1;
    chk(!oe && !dp && !dm && !done, "R1 reset state", 64'({oe, dp, dm, done}), 64'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!oe && !done, "R1 idle after reset", 64'({oe, done}), 64'd0);

    for (int v = 0; v < NV; v++) begin
      send(VEC[v][77:75], VEC[v][74:68], VEC[v][67:64], VEC[v][63:0], -1);
      verify(VEC[v][77:75], VEC[v][74:68], VEC[v][67:64], VEC[v][63:0]);
    end

    send(3'd0, 7'd5, 7'd4, 64'h0, 10);
    verify(3'd0, 7'd5, 4'd4, 64'h0);
    repeat (3) begin
      @(negedge clk);
      chk(!oe, "R11 no queued packet", 64'(oe), 64'd0);
    end

    @(negedge clk);
    kind = 3'd5; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) begin
      chk(!oe, "R12 unknown kind ignored", 64'(oe), 64'd0);
      @(negedge clk);
    end

    kind = 3'd2; pl = 64'h5555_aaaa_0f0f_f0f0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    chk(oe, "R1 packet in flight before reset", 64'(oe), 64'd1);
    rst_n = 1'b0;
    #1;
    chk(!oe && !dp && !dm, "R1 reset mid packet", 64'({oe, dp, dm}), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    send(3'd4, 7'd0, 4'd0, 64'h0, -1);
    verify(3'd4, 7'd0, 4'd0, 64'h0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule